// File: doc/BRIEF.md
# Status-Flag Arithmetic/Logic Unit

This block is the arithmetic/logic stage of a small RISC core. Each cycle it may accept one operation: two data operands and an operation code. It returns a registered result, a registered write-back enable for the register file, and an 8-bit status register. The status register holds six arithmetic flags and two general bits. The arithmetic flags are half-carry, sign, overflow, negative, zero and carry.

The carry-in for the carry-chained operations is the stored carry flag. Each operation updates only its own subset of flags and leaves the others as they were. Two operations set or clear any single status bit, chosen by an index. Instruction decode, the register file, branching and memory access sit outside the block.

Top module: `status_alu`

## Requirements
- R1: After reset, and during any cycle with `rst_n` low, `result`, `wr_en` and `status` are all zero.
- R2: An accepted operation (`op_valid` high at a rising edge) is visible on `result`, `wr_en` and `status` right after that edge. Status bit positions, bit 7 down to 0, are: I, T, H (half-carry), S (sign), V (overflow), N (negative), Z (zero), C (carry). Opcode values: NOP 0, ADD 1, ADC 2, SUB 3, SBC 4, CMP 5, CPC 6, AND 7, OR 8, XOR 9, COM 10, NEG 11, INC 12, DEC 13, LSR 14, ROR 15, ASR 16, LSL 17, ROL 18, SWAP 19, FSET 20, FCLR 21.
- R3: The following operations update H, V, N, Z and C and assert write-back: ADD, ADC, SUB and SBC. ADC adds the stored C. SBC subtracts the stored C. H is the carry or borrow out of bit 3. V is two's-complement overflow.
- R4: AND, OR and XOR write back and update N and Z. They clear V and leave C and H unchanged.
- R5: INC and DEC write back and update V, N and Z. They leave C and H unchanged.
- R6: CMP and CPC update H, V, N, Z and C like SUB and SBC, with write-back low. For CPC and SBC, Z ends set only when the difference is zero and Z was already set.
- R7: COM gives the bitwise inverse. It sets C to 1, clears V, and leaves H alone. NEG gives zero minus the operand and updates H, V, N, Z and C, with C set for any nonzero operand.
- R8: The shifts work as follows. LSR shifts in a zero at the top. ROR shifts the stored C in at the top. ASR keeps the top bit. All three move bit 0 into C. LSL and ROL shift left, ROL shifting the stored C in at bit 0, and bit 7 goes to C and bit 3 to H. For every shift, V equals N XOR C.
- R9: SWAP exchanges the upper and lower nibbles, writes back, and leaves every status bit unchanged.
- R10: After any operation that updates N or V, S equals N XOR V.
- R11: FSET sets and FCLR clears the status bit indexed by `opb[2:0]`. Neither asserts write-back. Neither changes any other status bit.
- R12: A cycle with `op_valid` low leaves `result` and `status` unchanged and has no effect at the ports beyond dropping `wr_en`. The same holds for NOP and undefined opcodes (22 to 31) issued with `op_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 5 | Operation code (see R2) |
| opa | input | W | First operand (destination operand) |
| opb | input | W | Second operand; bits 2..0 index the status bit for FSET/FCLR |
| result | output | W | Registered result |
| wr_en | output | 1 | Registered write-back enable |
| status | output | 8 | Status register I,T,H,S,V,N,Z,C |

## Verification
The bench builds the block with its default data width of 8. At that width the half-carry boundary falls at bit 3 and the sign bit at bit 7, so the overflow corners can be reached directly: 0x7F plus one, 0x80 minus one, and the negation of 0x80. The bench preloads the status register through the flag set and clear operations before every vector. Doing so drives the stored carry and zero flags into each chained add, subtract and compare, and it shows that untouched flags keep their preloaded values.

// File: rtl/salu_pkg.sv
package salu_pkg;

  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_ADC  = 5'd2,
    OP_SUB  = 5'd3,
    OP_SBC  = 5'd4,
    OP_CMP  = 5'd5,
    OP_CPC  = 5'd6,
    OP_AND  = 5'd7,
    OP_OR   = 5'd8,
    OP_XOR  = 5'd9,
    OP_COM  = 5'd10,
    OP_NEG  = 5'd11,
    OP_INC  = 5'd12,
    OP_DEC  = 5'd13,
    OP_LSR  = 5'd14,
    OP_ROR  = 5'd15,
    OP_ASR  = 5'd16,
    OP_LSL  = 5'd17,
    OP_ROL  = 5'd18,
    OP_SWAP = 5'd19,
    OP_FSET = 5'd20,
    OP_FCLR = 5'd21
  } salu_op_e;

  // Status bit positions (order is architectural: R2)
  localparam int unsigned SB_I = 7;
  localparam int unsigned SB_T = 6;
  localparam int unsigned SB_H = 5;
  localparam int unsigned SB_S = 4;
  localparam int unsigned SB_V = 3;
  localparam int unsigned SB_N = 2;
  localparam int unsigned SB_Z = 1;
  localparam int unsigned SB_C = 0;
  localparam int unsigned STATUS_W = 8;

  typedef struct packed {
    logic h;
    logic v;
    logic n;
    logic z;
    logic c;
  } salu_flags_t;

  function automatic logic op_is_arith(salu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC,
      OP_NEG, OP_INC, OP_DEC, OP_LSL, OP_ROL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_bitop(salu_op_e op);
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_COM,
      OP_LSR, OP_ROR, OP_ASR, OP_SWAP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_compare(salu_op_e op);
    return (op == OP_CMP) || (op == OP_CPC);
  endfunction

endpackage

// File: rtl/salu_arith.sv
module salu_arith
  import salu_pkg::*;
#(
  parameter int W = 8
) (
  input  salu_op_e    op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic        cin,
  input  logic        zin,
  output logic [W-1:0] res,
  output salu_flags_t flg,
  output salu_flags_t upd
);

  localparam int MSB = W - 1;
  localparam int HB  = W / 2 - 1;

  typedef struct packed {
    logic [W-1:0] r;
    logic         co;
    logic         hc;
    logic         ov;
  } sum_t;

  // carry out of the top bit and out of the low nibble, plus overflow
  function automatic sum_t add_f(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    sum_t          s;
    logic [W:0]    full;
    logic [HB+1:0] lo;
    full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    lo   = {1'b0, x[HB:0]} + {1'b0, y[HB:0]} + {{(HB+1){1'b0}}, ci};
    s.r  = full[W-1:0];
    s.co = full[W];
    s.hc = lo[HB+1];
    s.ov = ~(x[MSB] ^ y[MSB]) & (x[MSB] ^ full[MSB]);
    return s;
  endfunction

  // borrow out of the top bit and out of the low nibble, plus overflow
  function automatic sum_t sub_f(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    sum_t          s;
    logic [W:0]    full;
    logic [HB+1:0] lo;
    full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, ci};
    lo   = {1'b0, x[HB:0]} - {1'b0, y[HB:0]} - {{(HB+1){1'b0}}, ci};
    s.r  = full[W-1:0];
    s.co = full[W];
    s.hc = lo[HB+1];
    s.ov = (x[MSB] ^ y[MSB]) & (x[MSB] ^ full[MSB]);
    return s;
  endfunction

  logic [W-1:0] x_in;
  logic [W-1:0] y_in;
  logic         c_in;
  logic         do_sub;
  logic         z_chain;
  sum_t         sum;

  always_comb begin
    x_in    = a;
    y_in    = b;
    c_in    = 1'b0;
    do_sub  = 1'b0;
    z_chain = 1'b0;
    upd     = '1;
    case (op)
      OP_ADD: ;
      OP_ADC: c_in = cin;
      OP_LSL: y_in = a;
      OP_ROL: begin y_in = a; c_in = cin; end
      OP_SUB, OP_CMP: do_sub = 1'b1;
      OP_SBC, OP_CPC: begin do_sub = 1'b1; c_in = cin; z_chain = 1'b1; end
      OP_NEG: begin x_in = '0; y_in = a; do_sub = 1'b1; end
      OP_INC: begin y_in = {{(W-1){1'b0}}, 1'b1}; upd.h = 1'b0; upd.c = 1'b0; end
      OP_DEC: begin
        y_in = {{(W-1){1'b0}}, 1'b1}; do_sub = 1'b1;
        upd.h = 1'b0; upd.c = 1'b0;
      end
      default: upd = '0;
    endcase
    sum   = do_sub ? sub_f(x_in, y_in, c_in) : add_f(x_in, y_in, c_in);
    res   = sum.r;
    flg.h = sum.hc;
    flg.c = sum.co;
    flg.v = sum.ov;
    flg.n = sum.r[MSB];
    flg.z = (sum.r == '0) & (~z_chain | zin);
  end

endmodule

// File: rtl/salu_bitops.sv
module salu_bitops
  import salu_pkg::*;
#(
  parameter int W = 8
) (
  input  salu_op_e    op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic        cin,
  output logic [W-1:0] res,
  output salu_flags_t flg,
  output salu_flags_t upd
);

  localparam int MSB  = W - 1;
  localparam int HALF = W / 2;

  function automatic logic [W-1:0] swap_halves(logic [W-1:0] x);
    return {x[HALF-1:0], x[W-1:HALF]};
  endfunction

  logic [W-1:0] r;
  logic         c_new;
  logic         shift_op;

  always_comb begin
    r        = a;
    c_new    = 1'b0;
    shift_op = 1'b0;
    upd      = '0;
    case (op)
      OP_AND: begin r = a & b; upd.v = 1'b1; upd.n = 1'b1; upd.z = 1'b1; end
      OP_OR:  begin r = a | b; upd.v = 1'b1; upd.n = 1'b1; upd.z = 1'b1; end
      OP_XOR: begin r = a ^ b; upd.v = 1'b1; upd.n = 1'b1; upd.z = 1'b1; end
      OP_COM: begin
        r = ~a; c_new = 1'b1;
        upd.c = 1'b1; upd.v = 1'b1; upd.n = 1'b1; upd.z = 1'b1;
      end
      OP_LSR: begin r = {1'b0, a[MSB:1]};    c_new = a[0]; shift_op = 1'b1; end
      OP_ROR: begin r = {cin, a[MSB:1]};     c_new = a[0]; shift_op = 1'b1; end
      OP_ASR: begin r = {a[MSB], a[MSB:1]};  c_new = a[0]; shift_op = 1'b1; end
      OP_SWAP: r = swap_halves(a);
      default: r = a;
    endcase
    if (shift_op) begin
      upd.c = 1'b1; upd.v = 1'b1; upd.n = 1'b1; upd.z = 1'b1;
    end
    res   = r;
    flg.h = 1'b0;
    flg.c = c_new;
    flg.n = r[MSB];
    flg.z = (r == '0);
    flg.v = shift_op ? (r[MSB] ^ c_new) : 1'b0;
  end

endmodule

// File: rtl/salu_flag_merge.sv
module salu_flag_merge
  import salu_pkg::*;
(
  input  logic [STATUS_W-1:0] cur,
  input  salu_flags_t         flg,
  input  salu_flags_t         upd,
  input  logic                do_set,
  input  logic                do_clr,
  input  logic [2:0]          idx,
  output logic [STATUS_W-1:0] nxt
);

  logic [STATUS_W-1:0] merged;

  always_comb begin
    merged = cur;
    if (upd.h) merged[SB_H] = flg.h;
    if (upd.v) merged[SB_V] = flg.v;
    if (upd.n) merged[SB_N] = flg.n;
    if (upd.z) merged[SB_Z] = flg.z;
    if (upd.c) merged[SB_C] = flg.c;
    if (upd.v | upd.n) merged[SB_S] = merged[SB_N] ^ merged[SB_V];
  end

  always_comb begin
    nxt = merged;
    if (do_set)      nxt[idx] = 1'b1;
    else if (do_clr) nxt[idx] = 1'b0;
  end

endmodule

// File: rtl/status_alu.sv
module status_alu
  import salu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [4:0]          op_code,
  input  logic [W-1:0]        opa,
  input  logic [W-1:0]        opb,
  output logic [W-1:0]        result,
  output logic                wr_en,
  output logic [STATUS_W-1:0] status
);

  localparam int FIDX_W = 3;

  salu_op_e    op;
  logic [W-1:0] ar_res, bo_res, unit_res;
  salu_flags_t ar_flg, bo_flg, ar_upd, bo_upd, unit_flg, unit_upd;
  logic        sel_arith, sel_bitop, is_cmp, flag_set, flag_clr;
  logic        wb_next, load_res;
  logic [STATUS_W-1:0] status_next;

  assign op        = salu_op_e'(op_code);
  assign sel_arith = op_is_arith(op);
  assign sel_bitop = op_is_bitop(op);
  assign is_cmp    = op_is_compare(op);
  assign flag_set  = (op == OP_FSET);
  assign flag_clr  = (op == OP_FCLR);

  salu_arith #(.W(W)) u_arith (
    .op (op), .a (opa), .b (opb),
    .cin(status[SB_C]), .zin(status[SB_Z]),
    .res(ar_res), .flg(ar_flg), .upd(ar_upd)
  );

  salu_bitops #(.W(W)) u_bitops (
    .op (op), .a (opa), .b (opb), .cin(status[SB_C]),
    .res(bo_res), .flg(bo_flg), .upd(bo_upd)
  );

  always_comb begin
    unit_res = sel_arith ? ar_res : bo_res;
    unit_flg = sel_arith ? ar_flg : bo_flg;
    unit_upd = sel_arith ? ar_upd : (sel_bitop ? bo_upd : '0);
  end

  assign load_res = sel_arith | sel_bitop;
  assign wb_next  = load_res & ~is_cmp;

  salu_flag_merge u_merge (
    .cur   (status),
    .flg   (unit_flg),
    .upd   (unit_upd),
    .do_set(flag_set),
    .do_clr(flag_clr),
    .idx   (opb[FIDX_W-1:0]),
    .nxt   (status_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      wr_en  <= 1'b0;
      status <= '0;
    end else begin
      wr_en <= op_valid & wb_next;
      if (op_valid) status <= status_next;
      if (op_valid & load_res) result <= unit_res;
    end
  end

endmodule

// File: rtl/salu_checker.sv
module salu_checker
  import salu_pkg::*;
#(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_valid,
  input logic [4:0]          op_code,
  input logic [W-1:0]        opa,
  input logic [W-1:0]        result,
  input logic                wr_en,
  input logic [STATUS_W-1:0] status
);

  localparam int HALF = W / 2;

  // R6: compares never write back
  p_cmp_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_CMP || op_code == OP_CPC) |=> !wr_en);

  // R5: increment/decrement keep carry and half-carry
  p_incdec_keep_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_INC || op_code == OP_DEC)
    |=> status[SB_C] == $past(status[SB_C]) && status[SB_H] == $past(status[SB_H]));

  // R4: logic ops keep C and H, clear V
  p_logic_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR)
    |=> status[SB_C] == $past(status[SB_C]) && status[SB_H] == $past(status[SB_H])
        && !status[SB_V]);

  // R7: one's complement forces carry, clears overflow
  p_com_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_COM |=> status[SB_C] && !status[SB_V]);

  // R9: nibble swap keeps flags and exchanges halves
  p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_SWAP
    |=> status == $past(status) && wr_en
        && result == {$past(opa[HALF-1:0]), $past(opa[W-1:HALF])});

  // R10: sign equals N xor V after every flag-producing operation
  p_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code >= OP_ADD && op_code <= OP_ROL
    |=> status[SB_S] == (status[SB_N] ^ status[SB_V]));

  // R12: idle cycles hold state and drop write-back
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !wr_en && $stable(status) && $stable(result));

endmodule

bind status_alu salu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .opa(opa), .result(result), .wr_en(wr_en), .status(status)
);

// File: tb/sim_status_alu.sv
module sim_status_alu;
  import salu_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = 5'd0;
  logic [7:0] opa = 8'h00;
  logic [7:0] opb = 8'h00;
  logic [7:0] result;
  logic       wr_en;
  logic [7:0] status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  status_alu #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opa(opa), .opb(opb), .result(result), .wr_en(wr_en), .status(status)
  );

  // {req, init status, op, a, b, exp result, exp wb, exp status}
  localparam int NV = 31;
  localparam logic [53:0] VEC [NV] = '{
    {8'd3,  8'h00, OP_ADD,  8'h0F, 8'h01, 8'h10, 1'b1, 8'h20}, // R3 half-carry
    {8'd3,  8'h00, OP_ADD,  8'h7F, 8'h01, 8'h80, 1'b1, 8'h2C}, // R3 overflow
    {8'd3,  8'h00, OP_ADD,  8'hFF, 8'h01, 8'h00, 1'b1, 8'h23}, // R3 carry+zero
    {8'd3,  8'h01, OP_ADC,  8'h10, 8'h20, 8'h31, 1'b1, 8'h00}, // R3 carry in
    {8'd3,  8'h01, OP_ADC,  8'h0F, 8'h00, 8'h10, 1'b1, 8'h20}, // R3
    {8'd3,  8'h00, OP_SUB,  8'h10, 8'h01, 8'h0F, 1'b1, 8'h20}, // R3 nibble borrow
    {8'd3,  8'h00, OP_SUB,  8'h00, 8'h01, 8'hFF, 1'b1, 8'h35}, // R3 borrow
    {8'd10, 8'h00, OP_SUB,  8'h80, 8'h01, 8'h7F, 1'b1, 8'h38}, // R10 S=1,N=0
    {8'd6,  8'h02, OP_SBC,  8'h05, 8'h05, 8'h00, 1'b1, 8'h02}, // R6 Z chain kept
    {8'd6,  8'h01, OP_SBC,  8'h10, 8'h0F, 8'h00, 1'b1, 8'h20}, // R6 Z chain drops
    {8'd6,  8'h00, OP_CPC,  8'h00, 8'h00, 8'h00, 1'b0, 8'h00}, // R6
    {8'd6,  8'hC0, OP_CMP,  8'h03, 8'h05, 8'hFE, 1'b0, 8'hF5}, // R6 I,T kept
    {8'd6,  8'h00, OP_CMP,  8'h05, 8'h05, 8'h00, 1'b0, 8'h02}, // R6
    {8'd4,  8'h29, OP_AND,  8'hF0, 8'h8F, 8'h80, 1'b1, 8'h35}, // R4
    {8'd4,  8'h21, OP_OR,   8'h00, 8'h00, 8'h00, 1'b1, 8'h23}, // R4
    {8'd4,  8'h08, OP_XOR,  8'hAA, 8'hAA, 8'h00, 1'b1, 8'h02}, // R4 V cleared
    {8'd7,  8'h00, OP_COM,  8'h0F, 8'h00, 8'hF0, 1'b1, 8'h15}, // R7
    {8'd7,  8'h00, OP_NEG,  8'h01, 8'h00, 8'hFF, 1'b1, 8'h35}, // R7
    {8'd7,  8'h00, OP_NEG,  8'h80, 8'h00, 8'h80, 1'b1, 8'h0D}, // R7 overflow
    {8'd7,  8'h01, OP_NEG,  8'h00, 8'h00, 8'h00, 1'b1, 8'h02}, // R7 zero -> C=0
    {8'd5,  8'h01, OP_INC,  8'h7F, 8'h00, 8'h80, 1'b1, 8'h0D}, // R5
    {8'd5,  8'h00, OP_DEC,  8'h80, 8'h00, 8'h7F, 1'b1, 8'h18}, // R5
    {8'd5,  8'h21, OP_DEC,  8'h01, 8'h00, 8'h00, 1'b1, 8'h23}, // R5
    {8'd8,  8'h00, OP_LSR,  8'h81, 8'h00, 8'h40, 1'b1, 8'h19}, // R8
    {8'd8,  8'h01, OP_ROR,  8'h02, 8'h00, 8'h81, 1'b1, 8'h0C}, // R8
    {8'd8,  8'h00, OP_ASR,  8'h81, 8'h00, 8'hC0, 1'b1, 8'h15}, // R8
    {8'd8,  8'h00, OP_LSL,  8'h88, 8'h00, 8'h10, 1'b1, 8'h39}, // R8
    {8'd8,  8'h01, OP_ROL,  8'h40, 8'h00, 8'h81, 1'b1, 8'h0C}, // R8
    {8'd9,  8'hFF, OP_SWAP, 8'h3C, 8'h00, 8'hC3, 1'b1, 8'hFF}, // R9
    {8'd11, 8'h00, OP_FSET, 8'h00, 8'h06, 8'h00, 1'b0, 8'h40}, // R11
    {8'd11, 8'hFF, OP_FCLR, 8'h00, 8'h00, 8'h00, 1'b0, 8'hFE}  // R11
  };

  task automatic check(input int req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_op(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b);
    op_valid = 1'b1; op_code = op; opa = a; opb = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic preload(input logic [7:0] v);
    for (int j = 0; j < 8; j++)
      do_op(v[j] ? OP_FSET : OP_FCLR, 8'h00, 8'(j));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(1, "reset result", result, 8'h00);
    check(1, "reset wr_en", {7'd0, wr_en}, 8'h00);
    check(1, "reset status", status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: one-cycle latency and status bit position (H at bit 5)
    do_op(OP_INC, 8'h41, 8'h00);
    check(2, "latency result", result, 8'h42);
    check(2, "latency wr_en", {7'd0, wr_en}, 8'h01);
    preload(8'h00);
    do_op(OP_FSET, 8'h00, 8'h05);
    check(2, "bit order H", status, 8'h20);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] rq, init, a, b, er, es;
      logic [4:0] op;
      logic       ew;
      {rq, init, op, a, b, er, ew, es} = VEC[i];
      preload(init);
      do_op(op, a, b);
      check(int'(rq), $sformatf("vec%0d status", i), status, es);
      check(int'(rq), $sformatf("vec%0d wr_en", i), {7'd0, wr_en}, {7'd0, ew});
      if (op != OP_FSET && op != OP_FCLR)
        check(int'(rq), $sformatf("vec%0d result", i), result, er);
    end

    // R12: idle cycles hold state
    preload(8'h00);
    do_op(OP_ADD, 8'h01, 8'h01);
    op_valid = 1'b0; op_code = OP_ADD; opa = 8'hFF; opb = 8'h01;
    repeat (2) @(negedge clk);
    check(12, "idle result", result, 8'h02);
    check(12, "idle wr_en", {7'd0, wr_en}, 8'h00);
    check(12, "idle status", status, 8'h00);

    // R12: undefined opcode and NOP with valid high
    do_op(5'd31, 8'hFF, 8'h01);
    check(12, "undef result", result, 8'h02);
    check(12, "undef wr_en", {7'd0, wr_en}, 8'h00);
    check(12, "undef status", status, 8'h00);
    do_op(OP_NOP, 8'hFF, 8'h01);
    check(12, "nop status", status, 8'h00);
    check(12, "nop result", result, 8'h02);

    // R11: flag op leaves result alone
    do_op(OP_FSET, 8'h00, 8'h00);
    check(11, "fset result", result, 8'h02);
    check(11, "fset status", status, 8'h01);

    // R1: reset during operation
    preload(8'hFF);
    do_op(OP_ADD, 8'h10, 8'h10);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, "midrun status", status, 8'h00);
    check(1, "midrun result", result, 8'h00);
    check(1, "midrun wr_en", {7'd0, wr_en}, 8'h00);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule